// File: doc/BRIEF.md
# Privilege Mode and Trap Controller

This block keeps the processor's privilege flag (kernel or user) and the registers that only kernel code may touch: the base of the user page table, the base of the kernel page table, and a saved return address. The instruction decoder gives it one operation per cycle: a sequential step, a jump, a system-call trap, a return from trap, or a privileged register write. The block registers the next program counter and the new mode. It also raises a flush strobe for the translation cache and a fault strobe for illegal operations.

A trap from user mode changes the mode and moves the program counter to a kernel entry address fixed by a parameter. Both happen on the same clock edge, so no user instruction ever runs while kernel mappings are live. The operand that comes with the trap has no effect on the target. The return operation is just as indivisible: it drops to user mode and resumes at the saved address in one step. A privileged request from user mode changes nothing and raises a fault. The same applies to a second trap while already in kernel mode.

Top module: `priv_trap_ctrl`

## Requirements
- R1: After synchronous reset the block is in kernel mode with `pc` equal to KERNEL_ENTRY. Both table bases read zero, and `tlb_flush` and `illegal_fault` are low.
- R2: `op_kind` codes are: 0 step, 1 jump, 2 trap, 3 return, 4 write user base, 5 write kernel base, 6 write return address, 7 reserved. Code 0 advances `pc` by INSN_BYTES, wrapping modulo 2^XLEN. Code 1 loads `pc` from `op_data`. Neither code changes the mode, in either mode.
- R3: Code 2 from user mode sets kernel mode and sets `pc` to KERNEL_ENTRY on the same edge, whatever `op_data` holds.
- R4: A user-mode trap saves `pc + INSN_BYTES` as the return address.
- R5: Code 3 in kernel mode sets user mode and loads `pc` with the return address, both on one edge.
- R6: Code 6 in kernel mode replaces the return address with `op_data` and advances `pc`.
- R7: Codes 4 and 5 in kernel mode load `op_data` into the user or kernel table base. `active_pt_base` shows the kernel base in kernel mode and the user base in user mode.
- R8: `tlb_flush` is high for the cycle after a successful trap entry, a successful return, or a successful user base write. It is low after any other operation.
- R9: In user mode, codes 3, 4, 5 and 6 each raise `illegal_fault` for one cycle. In either mode, code 7 does the same. A faulting operation leaves `pc`, the mode and both bases unchanged.
- R10: Code 2 in kernel mode faults and does not nest. The mode stays kernel, `pc` holds, and the saved return address is kept.
- R11: The mode leaves user only through a trap.
- R12: With `op_valid` low, all outputs hold and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_kind | input | 3 | Operation code (see R2) |
| op_data | input | XLEN | Jump target or register write value |
| pc | output | XLEN | Program counter |
| kernel_mode | output | 1 | High in kernel mode |
| user_pt_base | output | XLEN | User page table base |
| kernel_pt_base | output | XLEN | Kernel page table base |
| active_pt_base | output | XLEN | Base selected by the current mode |
| tlb_flush | output | 1 | Translation cache flush strobe |
| illegal_fault | output | 1 | Illegal operation strobe |

## Verification
The bench builds the block with XLEN of 16, INSN_BYTES of 2 and KERNEL_ENTRY of 16'hFF00. With a 16-bit counter, a few jumps near the top of the space are enough to make the sequential step and the saved return address wrap through zero. The entry address is far from any random jump target, so a trap that honoured `op_data` would stand out. Random streams drift between the two modes and often request privileged operations in the wrong mode. Back-to-back traps, nested trap attempts and flush-producing sequences come up many times each.

// File: rtl/priv_trap_pkg.sv
package priv_trap_pkg;

    typedef enum logic [2:0] {
        OP_SEQ    = 3'd0,
        OP_JUMP   = 3'd1,
        OP_TRAP   = 3'd2,
        OP_RET    = 3'd3,
        OP_WR_UPT = 3'd4,
        OP_WR_KPT = 3'd5,
        OP_WR_EPC = 3'd6,
        OP_RSVD   = 3'd7
    } op_kind_e;

    typedef enum logic {
        MODE_USER   = 1'b0,
        MODE_KERNEL = 1'b1
    } mode_e;

    typedef enum logic [2:0] {
        PC_HOLD  = 3'd0,
        PC_STEP  = 3'd1,
        PC_JUMP  = 3'd2,
        PC_ENTRY = 3'd3,
        PC_EPC   = 3'd4
    } pc_src_e;

    typedef struct packed {
        pc_src_e pc_src;
        logic    set_kernel;
        logic    set_user;
        logic    save_epc;
        logic    wr_upt;
        logic    wr_kpt;
        logic    wr_epc;
        logic    flush;
        logic    fault;
    } action_t;

    function automatic action_t decode_op(logic valid, op_kind_e kind, mode_e mode);
        action_t a;
        logic    kern;
        a      = '0;
        a.pc_src = PC_HOLD;
        kern   = (mode == MODE_KERNEL);
        if (valid) begin
            case (kind)
                OP_SEQ:  a.pc_src = PC_STEP;
                OP_JUMP: a.pc_src = PC_JUMP;
                OP_TRAP: begin
                    if (!kern) begin
                        a.pc_src     = PC_ENTRY;
                        a.set_kernel = 1'b1;
                        a.save_epc   = 1'b1;
                        a.flush      = 1'b1;
                    end else begin
                        a.fault = 1'b1;
                    end
                end
                OP_RET: begin
                    if (kern) begin
                        a.pc_src   = PC_EPC;
                        a.set_user = 1'b1;
                        a.flush    = 1'b1;
                    end else begin
                        a.fault = 1'b1;
                    end
                end
                OP_WR_UPT: begin
                    if (kern) begin
                        a.pc_src = PC_STEP;
                        a.wr_upt = 1'b1;
                        a.flush  = 1'b1;
                    end else begin
                        a.fault = 1'b1;
                    end
                end
                OP_WR_KPT: begin
                    if (kern) begin
                        a.pc_src = PC_STEP;
                        a.wr_kpt = 1'b1;
                    end else begin
                        a.fault = 1'b1;
                    end
                end
                OP_WR_EPC: begin
                    if (kern) begin
                        a.pc_src = PC_STEP;
                        a.wr_epc = 1'b1;
                    end else begin
                        a.fault = 1'b1;
                    end
                end
                default: a.fault = 1'b1;
            endcase
        end
        return a;
    endfunction

endpackage

// File: rtl/priv_decode.sv
module priv_decode
    import priv_trap_pkg::*;
(
    input  logic     op_valid,
    input  op_kind_e op_kind,
    input  mode_e    mode,
    output action_t  act
);
    always_comb begin
        act = decode_op(op_valid, op_kind, mode);
    end
endmodule

// File: rtl/priv_pc_unit.sv
module priv_pc_unit
    import priv_trap_pkg::*;
#(
    parameter int              XLEN         = 32,
    parameter int              INSN_BYTES   = 4,
    parameter logic [XLEN-1:0] KERNEL_ENTRY = XLEN'('h1000)
) (
    input  logic            clk,
    input  logic            rst,
    input  action_t         act,
    input  logic [XLEN-1:0] op_data,
    input  logic [XLEN-1:0] epc,
    output logic [XLEN-1:0] pc,
    output logic [XLEN-1:0] pc_seq
);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    logic [XLEN-1:0] pc_q, pc_d;

    assign pc_seq = pc_q + STEP;
    assign pc     = pc_q;

    always_comb begin
        case (act.pc_src)
            PC_STEP:  pc_d = pc_seq;
            PC_JUMP:  pc_d = op_data;
            PC_ENTRY: pc_d = KERNEL_ENTRY;
            PC_EPC:   pc_d = epc;
            default:  pc_d = pc_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) pc_q <= KERNEL_ENTRY;
        else     pc_q <= pc_d;
    end

    // R2
    seq_step_chk: assert property (@(posedge clk) disable iff (rst)
        act.pc_src == PC_STEP |=> pc_q == $past(pc_q) + STEP);
endmodule

// File: rtl/priv_regs.sv
module priv_regs
    import priv_trap_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  action_t         act,
    input  logic [XLEN-1:0] op_data,
    input  logic [XLEN-1:0] pc_seq,
    output mode_e           mode,
    output logic [XLEN-1:0] upt,
    output logic [XLEN-1:0] kpt,
    output logic [XLEN-1:0] epc,
    output logic            flush,
    output logic            fault
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode  <= MODE_KERNEL;
            upt   <= '0;
            kpt   <= '0;
            epc   <= '0;
            flush <= 1'b0;
            fault <= 1'b0;
        end else begin
            if (act.set_kernel)    mode <= MODE_KERNEL;
            else if (act.set_user) mode <= MODE_USER;
            if (act.wr_upt)        upt  <= op_data;
            if (act.wr_kpt)        kpt  <= op_data;
            if (act.save_epc)      epc  <= pc_seq;
            else if (act.wr_epc)   epc  <= op_data;
            flush <= act.flush;
            fault <= act.fault;
        end
    end

    // R9
    fault_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        act.fault |=> fault && $stable(upt) && $stable(kpt) && $stable(mode));
endmodule

// File: rtl/priv_trap_ctrl.sv
module priv_trap_ctrl
    import priv_trap_pkg::*;
#(
    parameter int              XLEN         = 32,
    parameter int              INSN_BYTES   = 4,
    parameter logic [XLEN-1:0] KERNEL_ENTRY = XLEN'('h1000)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            op_valid,
    input  logic [2:0]      op_kind,
    input  logic [XLEN-1:0] op_data,
    output logic [XLEN-1:0] pc,
    output logic            kernel_mode,
    output logic [XLEN-1:0] user_pt_base,
    output logic [XLEN-1:0] kernel_pt_base,
    output logic [XLEN-1:0] active_pt_base,
    output logic            tlb_flush,
    output logic            illegal_fault
);
    action_t         act;
    mode_e           mode;
    logic [XLEN-1:0] epc, pc_seq;
    op_kind_e        kind;

    assign kind = op_kind_e'(op_kind);

    priv_decode u_decode (
        .op_valid (op_valid),
        .op_kind  (kind),
        .mode     (mode),
        .act      (act)
    );

    priv_pc_unit #(
        .XLEN(XLEN), .INSN_BYTES(INSN_BYTES), .KERNEL_ENTRY(KERNEL_ENTRY)
    ) u_pc (
        .clk(clk), .rst(rst), .act(act), .op_data(op_data),
        .epc(epc), .pc(pc), .pc_seq(pc_seq)
    );

    priv_regs #(.XLEN(XLEN)) u_regs (
        .clk(clk), .rst(rst), .act(act), .op_data(op_data), .pc_seq(pc_seq),
        .mode(mode), .upt(user_pt_base), .kpt(kernel_pt_base), .epc(epc),
        .flush(tlb_flush), .fault(illegal_fault)
    );

    assign kernel_mode    = (mode == MODE_KERNEL);
    assign active_pt_base = kernel_mode ? kernel_pt_base : user_pt_base;

    // R3
    trap_entry_chk: assert property (@(posedge clk) disable iff (rst)
        op_valid && op_kind == 3'd2 && !kernel_mode
        |=> kernel_mode && pc == KERNEL_ENTRY && tlb_flush);

    // R5
    trap_return_chk: assert property (@(posedge clk) disable iff (rst)
        op_valid && op_kind == 3'd3 && kernel_mode
        |=> !kernel_mode && pc == $past(epc) && tlb_flush);

    // R10
    no_nest_chk: assert property (@(posedge clk) disable iff (rst)
        op_valid && op_kind == 3'd2 && kernel_mode
        |=> kernel_mode && illegal_fault && $stable(pc) && $stable(epc));

    // R11
    user_exit_chk: assert property (@(posedge clk) disable iff (rst)
        !kernel_mode && !(op_valid && op_kind == 3'd2) |=> !kernel_mode);

    // R8
    flush_cause_chk: assert property (@(posedge clk) disable iff (rst)
        op_valid && !(op_kind == 3'd2 || op_kind == 3'd3 || op_kind == 3'd4)
        |=> !tlb_flush);

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> $stable(pc) && $stable(kernel_mode) && !tlb_flush && !illegal_fault);
endmodule

// File: tb/test_priv_trap_ctrl.sv
module test_priv_trap_ctrl;
    localparam int              XLEN  = 16;
    localparam int              STEP  = 2;
    localparam logic [XLEN-1:0] ENTRY = 16'hFF00;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            op_valid = 1'b0;
    logic [2:0]      op_kind = 3'd0;
    logic [XLEN-1:0] op_data = '0;
    logic [XLEN-1:0] pc, upt, kpt, apt;
    logic            kmode, flush, fault;

    int n_checks = 0;
    int n_fails  = 0;

    // model state
    logic [XLEN-1:0] m_pc, m_upt, m_kpt, m_epc;
    logic            m_k, m_flush, m_fault;

    always #10 clk = ~clk;

    priv_trap_ctrl #(.XLEN(XLEN), .INSN_BYTES(STEP), .KERNEL_ENTRY(ENTRY)) i_priv_trap_ctrl (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind), .op_data(op_data),
        .pc(pc), .kernel_mode(kmode), .user_pt_base(upt), .kernel_pt_base(kpt),
        .active_pt_base(apt), .tlb_flush(flush), .illegal_fault(fault)
    );

    function automatic string tag_for(logic v, logic [2:0] k, logic kern);
        if (!v) return "R12";
        case (k)
            3'd0, 3'd1: return "R2";
            3'd2: return kern ? "R10" : "R3";
            3'd3: return kern ? "R5" : "R9";
            3'd4, 3'd5: return kern ? "R7" : "R9";
            3'd6: return kern ? "R6" : "R9";
            default: return "R9";
        endcase
    endfunction

    task automatic model_step(logic v, logic [2:0] k, logic [XLEN-1:0] d);
        m_flush = 1'b0;
        m_fault = 1'b0;
        if (!v) return;
        case (k)
            3'd0: m_pc = m_pc + XLEN'(STEP);
            3'd1: m_pc = d;
            3'd2: if (!m_k) begin
                      m_epc = m_pc + XLEN'(STEP); m_pc = ENTRY; m_k = 1'b1; m_flush = 1'b1;
                  end else m_fault = 1'b1;
            3'd3: if (m_k) begin
                      m_pc = m_epc; m_k = 1'b0; m_flush = 1'b1;
                  end else m_fault = 1'b1;
            3'd4: if (m_k) begin m_upt = d; m_pc = m_pc + XLEN'(STEP); m_flush = 1'b1; end
                  else m_fault = 1'b1;
            3'd5: if (m_k) begin m_kpt = d; m_pc = m_pc + XLEN'(STEP); end
                  else m_fault = 1'b1;
            3'd6: if (m_k) begin m_epc = d; m_pc = m_pc + XLEN'(STEP); end
                  else m_fault = 1'b1;
            default: m_fault = 1'b1;
        endcase
    endtask

    task automatic compare(string req);
        logic [XLEN*4+2:0] act_v, exp_v;
        act_v = {pc, kmode, upt, kpt, apt, flush, fault};
        exp_v = {m_pc, m_k, m_upt, m_kpt, (m_k ? m_kpt : m_upt), m_flush, m_fault};
        n_checks++;
        if (act_v !== exp_v) begin
            n_fails++;
            $display("FAIL %s actual pc=%h k=%b upt=%h kpt=%h apt=%h fl=%b ft=%b expected pc=%h k=%b upt=%h kpt=%h apt=%h fl=%b ft=%b",
                     req, pc, kmode, upt, kpt, apt, flush, fault,
                     m_pc, m_k, m_upt, m_kpt, (m_k ? m_kpt : m_upt), m_flush, m_fault);
        end
    endtask

    // called at a negedge; returns at the next negedge
    task automatic do_op(logic v, logic [2:0] k, logic [XLEN-1:0] d, string req_override);
        string req;
        logic  was_user;
        req      = (req_override != "") ? req_override : tag_for(v, k, m_k);
        was_user = !m_k;
        op_valid = v; op_kind = k; op_data = d;
        model_step(v, k, d);
        @(posedge clk);
        #5;
        compare(req);
        if (was_user && !(v && k == 3'd2)) begin
            // R11: only a trap leaves user mode
            n_checks++;
            if (kmode !== 1'b0) begin
                n_fails++;
                $display("FAIL R11 actual kernel_mode=%b expected 0", kmode);
            end
        end
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        m_pc = ENTRY; m_k = 1'b1; m_upt = '0; m_kpt = '0; m_epc = '0;
        m_flush = 1'b0; m_fault = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        compare("R1");
        @(negedge clk);

        do_op(1, 3'd0, 16'h0000, "R2");
        do_op(1, 3'd1, 16'h0200, "R2");
        do_op(1, 3'd4, 16'h1234, "R7");
        do_op(1, 3'd5, 16'h4321, "R7");
        do_op(1, 3'd6, 16'h0400, "R6");
        do_op(1, 3'd3, 16'h9999, "R5");
        do_op(1, 3'd0, 16'h0000, "R2");
        do_op(1, 3'd2, 16'h5555, "R3");
        do_op(1, 3'd2, 16'h0123, "R10");
        do_op(1, 3'd3, 16'h0000, "R4");
        do_op(1, 3'd4, 16'hAAAA, "R9");
        do_op(1, 3'd5, 16'hBBBB, "R9");
        do_op(1, 3'd6, 16'hCCCC, "R9");
        do_op(1, 3'd3, 16'h0000, "R9");
        do_op(1, 3'd7, 16'h0000, "R9");
        do_op(0, 3'd2, 16'h0000, "R12");
        do_op(1, 3'd1, 16'hFFFE, "R2");
        do_op(1, 3'd0, 16'h0000, "R2");
        do_op(1, 3'd1, 16'hFFFE, "R2");
        do_op(1, 3'd2, 16'h0000, "R4");
        do_op(1, 3'd3, 16'h0000, "R4");
        do_op(1, 3'd2, 16'h0000, "R8");
        do_op(1, 3'd4, 16'h0F0F, "R8");
        do_op(1, 3'd5, 16'h0F0F, "R8");
        do_op(1, 3'd7, 16'h0000, "R9");

        for (int i = 0; i < 4000; i++) begin
            int r;
            logic [2:0] k;
            r = $urandom_range(0, 15);
            if      (r < 4)  k = 3'd0;
            else if (r < 6)  k = 3'd1;
            else if (r < 9)  k = 3'd2;
            else if (r < 11) k = 3'd3;
            else             k = 3'(r - 7);
            do_op($urandom_range(0, 9) != 0, k, 16'($urandom), "");
        end

        finish_run();
    end
endmodule